// File: doc/BRIEF.md
# Routine Call and Return Frame Unit

This block carries out the stack-frame work that a stack machine needs when it enters or leaves a routine. It handles three kinds of work. A direct call goes to `offset + base register`. An indirect call goes through a two-word closure that already sits on top of the stack. A return gives back a result of `n` words and discards `d` words of arguments. The block shares one data memory with the rest of the machine through one combinational read port and one synchronous write port. It writes the frame words and the moved result words itself. When it finishes it holds the new code pointer, stack top and frame base on its outputs, together with a bank of display (static-chain) registers.

A sequencer raises `start_i` for one cycle with the decoded fields and the current machine pointers. It then waits for the one-cycle `done_o` pulse. A call whose target lies in the primitive window builds no frame. It finishes with `prim_o` set, so that a separate primitive handler can take over. A failing check finishes with an error code and touches no memory.

Top module: `frm_unit`

## Requirements
- R1: A direct call writes exactly three data words: the static link (`link_i`) at ST, the old LB at ST+1 and CP+1 at ST+2. No other data word changes.
- R2: After a successful direct call, CP = `ofs_i + base_i`, LB = the old ST, and ST = the old ST + 3.
- R3: An indirect call takes its target from the word at ST-1 and leaves the static link at ST-2 in place. It writes only the old LB at ST and CP+1 at ST+1. Afterwards LB = ST-2 and ST = ST+2.
- R4: A call target T with PRIM_BASE <= T < PRIM_BASE+PRIM_NUM finishes with `prim_o`=1 and `err_o`=0. It writes no memory, leaves CP/ST/LB equal to their inputs and leaves the display registers unchanged.
- R5: A call target T >= CODE_WORDS that is outside the primitive window finishes with `err_o`=3. It writes no memory and leaves CP/ST/LB unchanged.
- R6: A direct call with ST+3 > HT, or an indirect call with ST+2 > HT, finishes with `err_o`=1. It writes no memory and leaves CP/ST/LB unchanged. ST+3 = HT is still accepted.
- R7: A return reads the dynamic link at LB+1 and the return address at LB+2. It copies the `n` words at ST-n upward, in ascending order, to start at LB-d. Afterwards CP = the old word at LB+2, LB = the old word at LB+1 and ST = LB-d+n. No other word changes.
- R8: A return with LB < STACK_BASE+d or ST < LB+3+n, and an indirect call with ST < STACK_BASE+2, finish with `err_o`=2. They write no memory and leave CP/ST/LB unchanged.
- R9: After every successful call or return, display entry 1 holds the word at the new LB and entry k holds the word stored at the address in entry k-1. Entry k occupies bits [16k-1:16(k-1)] of `disp_o`.
- R10: Each accepted start produces exactly one `done_o` pulse, one cycle long. A `start_i` raised while an operation is in progress is ignored.
- R11: Op code 3 finishes with `err_o`=0 and `prim_o`=0. It writes no memory and leaves CP/ST/LB unchanged. Op codes are: 0 direct call, 1 indirect call, 2 return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request, sampled only when idle |
| op_i | input | 2 | 0 direct call, 1 indirect call, 2 return, 3 no operation |
| cnt_i | input | 4 | Result size n for a return |
| ofs_i | input | 16 | Displacement d (call offset or argument size) |
| base_i | input | 16 | Value of the base register selected by the r field |
| link_i | input | 16 | Value of the register chosen as static link |
| cp_i | input | 16 | Current code pointer |
| st_i | input | 16 | Current stack top |
| lb_i | input | 16 | Current frame base |
| ht_i | input | 16 | Stack limit |
| mem_raddr_o | output | 16 | Data memory read address |
| mem_rdata_i | input | 16 | Data memory read data, same cycle |
| mem_we_o | output | 1 | Data memory write enable |
| mem_waddr_o | output | 16 | Data memory write address |
| mem_wdata_o | output | 16 | Data memory write data |
| done_o | output | 1 | Operation complete pulse |
| err_o | output | 2 | 0 none, 1 overflow, 2 underflow, 3 bad code address |
| prim_o | output | 1 | Call target is a primitive |
| cp_o | output | 16 | New code pointer |
| st_o | output | 16 | New stack top |
| lb_o | output | 16 | New frame base |
| disp_o | output | 96 | Display entries 1..6, entry 1 in the low bits |

## Verification
A wrong write index or a wrong frame base shows up at the memory write port within the three frame-writing cycles. The bench sees it as a mismatched image of the whole memory at `done_o`. A wrong entry in the display chain spreads to every later entry, because each entry addresses the next read, so a single fault shows up as several mismatched fields in `disp_o` at the same done pulse. A misordered check, such as overflow tested before the primitive window, appears at once as a wrong `err_o` or `prim_o` two cycles after the start.

// File: rtl/frm_pkg.sv
package frm_pkg;

  typedef enum logic [1:0] {
    OP_CALL  = 2'd0,
    OP_CALLI = 2'd1,
    OP_RET   = 2'd2,
    OP_NOP   = 2'd3
  } frm_op_e;

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0,
    ERR_OVF  = 2'd1,
    ERR_UNF  = 2'd2,
    ERR_CODE = 2'd3
  } frm_err_e;

  typedef enum logic [2:0] {
    S_IDLE, S_DECIDE, S_WRITE, S_RDDYN, S_RDRET, S_COPY, S_DISP, S_FIN
  } frm_state_e;

  // words pushed past the limit
  function automatic logic push_overflows(input int unsigned top,
                                          input int unsigned words,
                                          input int unsigned limit);
    return (top + words) > limit;
  endfunction

  function automatic logic in_window(input int unsigned a,
                                     input int unsigned lo,
                                     input int unsigned len);
    return (a >= lo) && (a < lo + len);
  endfunction

  // return would drop below the stack base or below the frame plus results
  function automatic logic ret_underflows(input int unsigned lb,
                                          input int unsigned st,
                                          input int unsigned cnt,
                                          input int unsigned ofs,
                                          input int unsigned sbase);
    return (lb < sbase + ofs) || (st < lb + 3 + cnt);
  endfunction

  function automatic int unsigned frame_words(input frm_op_e op);
    return (op == OP_CALL) ? 3 : 2;
  endfunction

endpackage

// File: rtl/frm_check.sv
module frm_check
  import frm_pkg::*;
#(
  parameter int unsigned W          = 16,
  parameter int unsigned CODE_WORDS = 1024,
  parameter int unsigned PRIM_BASE  = 1024,
  parameter int unsigned PRIM_NUM   = 28,
  parameter int unsigned STACK_BASE = 16
) (
  input  frm_op_e        op_i,
  input  logic [W-1:0]   tgt_i,
  input  logic [W-1:0]   st_i,
  input  logic [W-1:0]   lb_i,
  input  logic [W-1:0]   ht_i,
  input  logic [W-1:0]   ofs_i,
  input  logic [3:0]     cnt_i,
  output logic           prim_o,
  output logic           bad_o,
  output logic           ovf_o,
  output logic           unf_o
);

  logic is_call;
  logic hit_prim;

  always_comb begin
    is_call  = (op_i == OP_CALL) || (op_i == OP_CALLI);
    hit_prim = in_window(32'(tgt_i), PRIM_BASE, PRIM_NUM);
    prim_o   = is_call && hit_prim;
    bad_o    = is_call && !hit_prim && (32'(tgt_i) >= CODE_WORDS);
    ovf_o    = is_call && push_overflows(32'(st_i), frame_words(op_i), 32'(ht_i));
    if (op_i == OP_RET)
      unf_o = ret_underflows(32'(lb_i), 32'(st_i), 32'(cnt_i), 32'(ofs_i), STACK_BASE);
    else if (op_i == OP_CALLI)
      unf_o = 32'(st_i) < STACK_BASE + 2;
    else
      unf_o = 1'b0;
  end

endmodule

// File: rtl/frm_display.sv
module frm_display #(
  parameter int unsigned W     = 16,
  parameter int unsigned NDISP = 6,
  parameter int unsigned IXW   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_i,
  input  logic [IXW-1:0]     idx_i,
  input  logic [W-1:0]       val_i,
  output logic [W-1:0]       prev_o,
  output logic [NDISP*W-1:0] flat_o
);

  generate
    for (genvar k = 0; k < NDISP; k++) begin : g_ent
      logic [W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            q <= '0;
        else if (ld_i && idx_i == IXW'(k))     q <= val_i;
      end
      assign flat_o[k*W +: W] = q;
    end
  endgenerate

  // entry just below the one being loaded: next link to follow
  always_comb begin
    prev_o = '0;
    for (int k = 1; k < int'(NDISP); k++)
      if (idx_i == IXW'(k)) prev_o = flat_o[(k-1)*W +: W];
  end

endmodule

// File: rtl/frm_unit.sv
module frm_unit
  import frm_pkg::*;
#(
  parameter int unsigned W          = 16,
  parameter int unsigned CODE_WORDS = 1024,
  parameter int unsigned PRIM_BASE  = 1024,
  parameter int unsigned PRIM_NUM   = 28,
  parameter int unsigned STACK_BASE = 16,
  parameter int unsigned NDISP      = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [1:0]         op_i,
  input  logic [3:0]         cnt_i,
  input  logic [W-1:0]       ofs_i,
  input  logic [W-1:0]       base_i,
  input  logic [W-1:0]       link_i,
  input  logic [W-1:0]       cp_i,
  input  logic [W-1:0]       st_i,
  input  logic [W-1:0]       lb_i,
  input  logic [W-1:0]       ht_i,
  output logic [W-1:0]       mem_raddr_o,
  input  logic [W-1:0]       mem_rdata_i,
  output logic               mem_we_o,
  output logic [W-1:0]       mem_waddr_o,
  output logic [W-1:0]       mem_wdata_o,
  output logic               done_o,
  output logic [1:0]         err_o,
  output logic               prim_o,
  output logic [W-1:0]       cp_o,
  output logic [W-1:0]       st_o,
  output logic [W-1:0]       lb_o,
  output logic [NDISP*W-1:0] disp_o
);

  localparam int unsigned IXW = $clog2(NDISP + 16);

  frm_state_e     state;
  frm_op_e        op_q;
  logic [3:0]     cnt_q;
  logic [W-1:0]   ofs_q, base_q, link_q, cp_q, st_q, lb_q, ht_q;
  logic [W-1:0]   res_cp, res_st, res_lb;
  logic [IXW-1:0] idx_q;
  frm_err_e       err_q;
  logic           prim_q;

  // named internal events
  logic [W-1:0]   tgt_w, frame_lb_w, chain_w;
  logic [IXW-1:0] wr_last_w;
  logic           chk_prim, chk_bad, chk_ovf, chk_unf;
  logic           disp_ld_w;

  assign tgt_w      = (op_q == OP_CALLI) ? mem_rdata_i : ofs_q + base_q;
  assign frame_lb_w = (op_q == OP_CALL) ? st_q : st_q - W'(2);
  assign wr_last_w  = (op_q == OP_CALL) ? IXW'(2) : IXW'(1);
  assign disp_ld_w  = (state == S_DISP);

  frm_check #(
    .W(W), .CODE_WORDS(CODE_WORDS), .PRIM_BASE(PRIM_BASE),
    .PRIM_NUM(PRIM_NUM), .STACK_BASE(STACK_BASE)
  ) u_check (
    .op_i(op_q), .tgt_i(tgt_w), .st_i(st_q), .lb_i(lb_q), .ht_i(ht_q),
    .ofs_i(ofs_q), .cnt_i(cnt_q),
    .prim_o(chk_prim), .bad_o(chk_bad), .ovf_o(chk_ovf), .unf_o(chk_unf)
  );

  frm_display #(.W(W), .NDISP(NDISP), .IXW(IXW)) u_disp (
    .clk(clk), .rst_n(rst_n), .ld_i(disp_ld_w), .idx_i(idx_q),
    .val_i(mem_rdata_i), .prev_o(chain_w), .flat_o(disp_o)
  );

  // read address per state
  always_comb begin
    unique case (state)
      S_DECIDE: mem_raddr_o = st_q - W'(1);
      S_RDDYN:  mem_raddr_o = lb_q + W'(1);
      S_RDRET:  mem_raddr_o = lb_q + W'(2);
      S_COPY:   mem_raddr_o = st_q - W'(cnt_q) + W'(idx_q);
      S_DISP:   mem_raddr_o = (idx_q == '0) ? res_lb : chain_w;
      default:  mem_raddr_o = '0;
    endcase
  end

  // write port
  always_comb begin
    mem_we_o    = 1'b0;
    mem_waddr_o = '0;
    mem_wdata_o = '0;
    if (state == S_WRITE) begin
      mem_we_o    = 1'b1;
      mem_waddr_o = st_q + W'(idx_q);
      if (op_q == OP_CALL) begin
        unique case (idx_q)
          IXW'(0): mem_wdata_o = link_q;
          IXW'(1): mem_wdata_o = lb_q;
          default: mem_wdata_o = cp_q + W'(1);
        endcase
      end else begin
        mem_wdata_o = (idx_q == '0) ? lb_q : cp_q + W'(1);
      end
    end else if (state == S_COPY) begin
      mem_we_o    = 1'b1;
      mem_waddr_o = lb_q - ofs_q + W'(idx_q);
      mem_wdata_o = mem_rdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      op_q   <= OP_NOP;
      cnt_q  <= '0;
      ofs_q  <= '0; base_q <= '0; link_q <= '0;
      cp_q   <= '0; st_q   <= '0; lb_q   <= '0; ht_q <= '0;
      res_cp <= '0; res_st <= '0; res_lb <= '0;
      idx_q  <= '0;
      err_q  <= ERR_NONE;
      prim_q <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (start_i) begin
          op_q   <= frm_op_e'(op_i);
          cnt_q  <= cnt_i;
          ofs_q  <= ofs_i;  base_q <= base_i; link_q <= link_i;
          cp_q   <= cp_i;   st_q   <= st_i;   lb_q   <= lb_i;  ht_q <= ht_i;
          state  <= S_DECIDE;
        end
        S_DECIDE: begin
          err_q  <= ERR_NONE;
          prim_q <= 1'b0;
          idx_q  <= '0;
          res_cp <= cp_q;
          res_st <= st_q;
          res_lb <= lb_q;
          state  <= S_FIN;
          if (op_q == OP_RET) begin
            if (chk_unf) err_q <= ERR_UNF;
            else         state <= S_RDDYN;
          end else if (op_q != OP_NOP) begin
            if (chk_unf)       err_q  <= ERR_UNF;
            else if (chk_prim) prim_q <= 1'b1;
            else if (chk_bad)  err_q  <= ERR_CODE;
            else if (chk_ovf)  err_q  <= ERR_OVF;
            else begin
              res_cp <= tgt_w;
              res_lb <= frame_lb_w;
              res_st <= st_q + W'(frame_words(op_q));
              state  <= S_WRITE;
            end
          end
        end
        S_WRITE: begin
          if (idx_q == wr_last_w) begin
            idx_q <= '0;
            state <= S_DISP;
          end else begin
            idx_q <= idx_q + IXW'(1);
          end
        end
        S_RDDYN: begin
          res_lb <= mem_rdata_i;
          state  <= S_RDRET;
        end
        S_RDRET: begin
          res_cp <= mem_rdata_i;
          res_st <= lb_q - ofs_q + W'(cnt_q);
          idx_q  <= '0;
          state  <= (cnt_q == '0) ? S_DISP : S_COPY;
        end
        S_COPY: begin
          if (idx_q == IXW'(cnt_q) - IXW'(1)) begin
            idx_q <= '0;
            state <= S_DISP;
          end else begin
            idx_q <= idx_q + IXW'(1);
          end
        end
        S_DISP: begin
          if (idx_q == IXW'(NDISP - 1)) begin
            idx_q <= '0;
            state <= S_FIN;
          end else begin
            idx_q <= idx_q + IXW'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign done_o = (state == S_FIN);
  assign err_o  = err_q;
  assign prim_o = prim_q;
  assign cp_o   = res_cp;
  assign st_o   = res_st;
  assign lb_o   = res_lb;

  // R1: direct-call writes land inside the three-word frame above the new base
  a_r1_call_frame_window: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && op_q == OP_CALL) |-> ((mem_waddr_o - res_lb) < W'(3)));

  // R3: closure-call writes skip the two closure words below them
  a_r3_closure_window: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && op_q == OP_CALLI) |->
      ((mem_waddr_o - res_lb) >= W'(2) && (mem_waddr_o - res_lb) < W'(4)));

  // R7: result copy always moves words downward
  a_r7_copy_downward: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && op_q == OP_RET) |-> (mem_waddr_o < mem_raddr_o));

  // R4: a primitive hand-off never carries an error code
  a_r4_prim_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && prim_o) |-> (err_o == 2'd0));

  // R5, R6, R8: a flagged error keeps the memory untouched
  a_r6_no_write_on_error: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q != ERR_NONE) |-> !mem_we_o);

  // R5: error completion keeps the code pointer
  a_r5_error_keeps_cp: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err_o != 2'd0) |-> (cp_o == cp_q));

  // R10: completion is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9: the display bank loads only while no memory write is under way
  a_r9_disp_after_writes: assert property (@(posedge clk) disable iff (!rst_n)
    disp_ld_w |-> !mem_we_o);

endmodule

// File: tb/tb_frm_unit.sv
module tb_frm_unit;

  localparam int W     = 16;
  localparam int CW    = 1024;
  localparam int PB    = 1024;
  localparam int PN    = 28;
  localparam int SB    = 16;
  localparam int ND    = 6;
  localparam int MEMN  = 4096;
  localparam int MASK  = MEMN - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          start_i = 1'b0;
  logic [1:0]    op_i = '0;
  logic [3:0]    cnt_i = '0;
  logic [W-1:0]  ofs_i = '0, base_i = '0, link_i = '0, cp_i = '0, st_i = '0, lb_i = '0, ht_i = '0;
  logic [W-1:0]  mem_raddr, mem_rdata, mem_waddr, mem_wdata;
  logic          mem_we, done_o, prim_o;
  logic [1:0]    err_o;
  logic [W-1:0]  cp_o, st_o, lb_o;
  logic [ND*W-1:0] disp_o;

  logic [15:0] mem     [MEMN];
  logic [15:0] exp_mem [MEMN];
  logic [15:0] edisp   [ND];

  int nchk = 0;
  int nfail = 0;

  frm_unit #(.W(W), .CODE_WORDS(CW), .PRIM_BASE(PB), .PRIM_NUM(PN),
             .STACK_BASE(SB), .NDISP(ND)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .cnt_i(cnt_i),
    .ofs_i(ofs_i), .base_i(base_i), .link_i(link_i), .cp_i(cp_i), .st_i(st_i),
    .lb_i(lb_i), .ht_i(ht_i), .mem_raddr_o(mem_raddr), .mem_rdata_i(mem_rdata),
    .mem_we_o(mem_we), .mem_waddr_o(mem_waddr), .mem_wdata_o(mem_wdata),
    .done_o(done_o), .err_o(err_o), .prim_o(prim_o), .cp_o(cp_o), .st_o(st_o),
    .lb_o(lb_o), .disp_o(disp_o)
  );

  assign mem_rdata = mem[mem_raddr[11:0]];
  always @(posedge clk) if (mem_we) mem[mem_waddr[11:0]] <= mem_wdata;

  task automatic chk(input string tag, input int act, input int expv);
    nchk++;
    if (act != expv) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic run_op(input int op, input int n, input int d, input int base,
                        input int link, input int cp, input int st, input int lb,
                        input int ht, input bit poke, input string tag);
    int ecp, est, elb, eerr, eprim, tgt, cyc, bad;
    bit ok;
    for (int i = 0; i < MEMN; i++) exp_mem[i] = mem[i];
    ecp = cp; est = st; elb = lb; eerr = 0; eprim = 0; ok = 0;
    if (op == 0 || op == 1) begin
      int words;
      words = (op == 0) ? 3 : 2;
      if (op == 1 && st < SB + 2) eerr = 2;
      else begin
        tgt = (op == 0) ? ((d + base) & 16'hFFFF) : int'(mem[(st - 1) & MASK]);
        if (tgt >= PB && tgt < PB + PN) eprim = 1;
        else if (tgt >= CW)             eerr = 3;
        else if (st + words > ht)       eerr = 1;
        else begin
          ok = 1;
          if (op == 0) begin
            exp_mem[st] = 16'(link); exp_mem[st+1] = 16'(lb); exp_mem[st+2] = 16'(cp + 1);
            elb = st;
          end else begin
            exp_mem[st] = 16'(lb); exp_mem[st+1] = 16'(cp + 1);
            elb = st - 2;
          end
          est = st + words;
          ecp = tgt;
        end
      end
    end else if (op == 2) begin
      if (lb < SB + d || st < lb + 3 + n) eerr = 2;
      else begin
        ok = 1;
        elb = int'(mem[lb + 1]);
        ecp = int'(mem[lb + 2]);
        for (int i = 0; i < n; i++) exp_mem[lb - d + i] = exp_mem[st - n + i];
        est = lb - d + n;
      end
    end
    if (ok) begin
      edisp[0] = exp_mem[elb & MASK];
      for (int k = 1; k < ND; k++) edisp[k] = exp_mem[int'(edisp[k-1]) & MASK];
    end

    @(negedge clk);
    op_i = 2'(op); cnt_i = 4'(n); ofs_i = 16'(d); base_i = 16'(base);
    link_i = 16'(link); cp_i = 16'(cp); st_i = 16'(st); lb_i = 16'(lb); ht_i = 16'(ht);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      op_i = 2'd2;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    cyc = 0;
    while (!done_o && cyc < 64) begin
      @(negedge clk);
      cyc++;
    end
    chk({tag, " R10 done seen"}, int'(done_o), 1);
    chk({tag, " cp"},   int'(cp_o),   ecp & 16'hFFFF);
    chk({tag, " st"},   int'(st_o),   est & 16'hFFFF);
    chk({tag, " lb"},   int'(lb_o),   elb & 16'hFFFF);
    chk({tag, " err"},  int'(err_o),  eerr);
    chk({tag, " prim"}, int'(prim_o), eprim);
    for (int k = 0; k < ND; k++)
      chk({tag, " R9 display"}, int'(disp_o[k*W +: W]), int'(edisp[k]));
    bad = 0;
    for (int i = 0; i < MEMN; i++) if (mem[i] !== exp_mem[i]) bad++;
    chk({tag, " memory words differing"}, bad, 0);
    if (poke) begin
      int extra;
      extra = 0;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        if (done_o) extra++;
      end
      chk({tag, " R10 extra done pulses"}, extra, 0);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog R10 actual=hung expected=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < MEMN; i++) mem[i] = 16'((i * 37 + 11) % 4000);
    for (int k = 0; k < ND; k++) edisp[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset R10 done", int'(done_o), 0);
    chk("reset R10 we", int'(mem_we), 0);
    chk("reset R6 err", int'(err_o), 0);
    chk("reset R4 prim", int'(prim_o), 0);
    chk("reset R2 cp", int'(cp_o), 0);
    chk("reset R9 disp", int'(disp_o[W-1:0]), 0);

    // R1 R2 R9: direct calls over several frames
    for (int i = 0; i < 12; i++)
      run_op(0, 0, i*5, 100, 200 + i*3, 40 + i, 300 + i*7, 260 + i, 1000, 0, "R1 R2 call");

    // R4 R5: primitive window edges and code limit
    run_op(0, 0, 24, 1000, 210, 50, 400, 380, 1000, 0, "R4 prim first");
    run_op(0, 0, 51, 1000, 210, 50, 400, 380, 1000, 0, "R4 prim last");
    run_op(0, 0, 52, 1000, 210, 50, 400, 380, 1000, 0, "R5 past prims");
    run_op(0, 0, 23, 1000, 210, 50, 400, 380, 1000, 0, "R5 last code word");
    run_op(0, 0, 3000, 1000, 210, 50, 400, 380, 1000, 0, "R5 far target");

    // R6: stack limit edges
    run_op(0, 0, 5, 100, 220, 60, 497, 480, 500, 0, "R6 call fits");
    run_op(0, 0, 5, 100, 220, 60, 498, 480, 500, 0, "R6 call overflow");

    // R3: closure calls
    for (int i = 0; i < 8; i++) begin
      mem[600 + i*4 - 1] = 16'(50 + i*9);
      mem[600 + i*4 - 2] = 16'(300 + i);
      run_op(1, 0, 0, 0, 0, 70 + i, 600 + i*4, 580, 1000, 0, "R3 closure call");
    end
    mem[17] = 16'd5;
    run_op(1, 0, 0, 0, 0, 10, 17, 16, 1000, 0, "R8 closure underflow");
    run_op(1, 0, 0, 0, 0, 10, 18, 16, 1000, 0, "R8 closure at base");
    mem[699] = 16'd1030;
    run_op(1, 0, 0, 0, 0, 10, 700, 690, 1000, 0, "R4 closure prim");
    mem[699] = 16'd33;
    run_op(1, 0, 0, 0, 0, 10, 700, 690, 701, 0, "R6 closure overflow");
    run_op(1, 0, 0, 0, 0, 10, 700, 690, 702, 0, "R6 closure fits");

    // R7 R9: returns over result and argument sizes
    for (int n = 0; n < 4; n++)
      for (int d = 0; d < 4; d++) begin
        int lb;
        lb = 800 + n*40 + d*10;
        mem[lb + 1] = 16'(400 + n);
        mem[lb + 2] = 16'(90 + d);
        run_op(2, n, d, 0, 0, 5, lb + 5 + n, lb, 1000, 0, "R7 return");
      end
    run_op(2, 0, 5, 0, 0, 5, 30, 20, 1000, 0, "R8 return below base");
    mem[22] = 16'd111; mem[23] = 16'd77;
    run_op(2, 0, 5, 0, 0, 5, 24, 21, 1000, 0, "R8 return at base");
    run_op(2, 0, 0, 0, 0, 5, 502, 500, 1000, 0, "R8 return short stack");

    // R11: no-op code
    run_op(3, 2, 7, 100, 200, 44, 333, 320, 1000, 0, "R11 nop");

    // R10: start during a busy call is ignored
    run_op(0, 0, 9, 100, 230, 61, 350, 340, 1000, 1, "R10 busy start");

    finish_run();
  end

endmodule